// File: doc/BRIEF.md
# Grouped Lookup-Table Neuron

This block evaluates one quantized neuron entirely by table lookup. A wide input vector of low-bit quantized features is cut into A fixed, disjoint groups of F features each. Every group forms the address of its own private sub-table. Each entry of a sub-table holds the pre-computed response of a multivariate polynomial over that group's inputs, stored as a small signed number, so no polynomial arithmetic happens in hardware. The A signed partial values are added in a balanced tree. The sum is then compared against a set of ascending signed thresholds, which fold in the normalisation and the activation, to give a 1- or 2-bit output code.

The block accepts one input vector per clock cycle. A parameter places either one register stage (after the quantizer) or two (one after the table read and one after the adder and quantizer), which trades clock rate against latency. Table entries and thresholds are loaded through a simple write port whose target selector picks a sub-table or the threshold bank. Loading happens while no input vectors are being presented. In the default configuration there are two groups of six 2-bit features (4096-entry sub-tables), 4-bit partials, a 5-bit sum and a 2-bit code with three thresholds.

Top module: `grouped_lut_neuron`

## Requirements
- R1: While reset is held and in the first cycle after it is released, with no input presented, out_valid is 0 and out_code is 0.
- R2: Group g is formed from in_vec bits [g*F*BETA +: F*BETA], with group 0 in the least significant bits. That slice addresses sub-table g only. The entry read is treated as a P_W-bit two's-complement partial.
- R3: The sum of all A partials is formed at P_W + ceil(log2(A)) bits and never overflows. This covers the extremes of every partial at its most negative value and every partial at its most positive value.
- R4: out_code equals the number of thresholds for which the signed sum is greater than or equal to the threshold; equality counts as met. There are 2^OUT_W - 1 thresholds.
- R5: Every accepted vector gives exactly one out_valid pulse, exactly STAGES cycles after its in_valid cycle (STAGES is 1 or 2). No other out_valid pulses occur.
- R6: Vectors presented on consecutive cycles are all accepted, and their results appear on consecutive cycles in the same order.
- R7: A write (cfg_we = 1) with cfg_tgt below A stores cfg_wdata[P_W-1:0] into sub-table cfg_tgt at index cfg_addr. A write with cfg_tgt = A stores cfg_wdata into threshold cfg_addr if cfg_addr is below 2^OUT_W - 1; a higher index is ignored. A write with cfg_tgt above A is ignored. Writes are made only while in_valid is 0.
- R8: While out_valid is 0, out_code keeps the last code delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector strobe |
| in_vec | input | A*F*BETA | Packed quantized features, group 0 in the low bits |
| cfg_we | input | 1 | Write strobe for table and threshold loading |
| cfg_tgt | input | ceil(log2(A+1)) | Write target: sub-table index, or A for the threshold bank |
| cfg_addr | input | F*BETA | Sub-table index or threshold number |
| cfg_wdata | input | P_W+ceil(log2(A)) | Write data (sub-tables take the low P_W bits) |
| out_valid | output | 1 | Output code strobe |
| out_code | output | OUT_W | Quantized activation |

## Verification
The output code of a vector is due exactly STAGES cycles after the cycle in which the vector was presented. The bench drives two instances, one with STAGES = 2 and one with STAGES = 1, from the same stimulus. The driver records, for every vector it presents, the expected code and the cycle at which the result is due, computed from its own model of the loaded tables and thresholds. The monitor samples on the falling edge and checks both the code and the cycle against that record. Any pulse that arrives without a pending item is reported, and the code is checked for stability on every cycle without a pulse.

// File: rtl/gln_pkg.sv
package gln_pkg;

    typedef enum logic [1:0] {
        GLN_TGT_TABLE,
        GLN_TGT_THRESH,
        GLN_TGT_NONE
    } gln_tgt_e;

    function automatic gln_tgt_e gln_decode(input int unsigned tgt, input int unsigned groups);
        if (tgt < groups)
            return GLN_TGT_TABLE;
        else if (tgt == groups)
            return GLN_TGT_THRESH;
        else
            return GLN_TGT_NONE;
    endfunction

endpackage

// File: rtl/gln_subtable.sv
module gln_subtable #(
    parameter int ADDR_W = 12,
    parameter int P_W    = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [P_W-1:0]    wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [P_W-1:0]    rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [P_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/gln_adder_tree.sv
module gln_adder_tree #(
    parameter int A     = 2,
    parameter int P_W   = 4,
    parameter int SUM_W = 5
) (
    input  logic [A*P_W-1:0]        parts,
    output logic signed [SUM_W-1:0] sum
);
    localparam int LV = $clog2(A);
    localparam int NP = 1 << LV;
    localparam int NN = 2 * NP - 1;

    logic signed [SUM_W-1:0] node [NN];

    for (genvar i = 0; i < NP; i++) begin : g_leaf
        if (i < A) begin : g_used
            assign node[NP-1+i] = SUM_W'($signed(parts[i*P_W +: P_W]));
        end else begin : g_pad
            assign node[NP-1+i] = '0;
        end
    end

    for (genvar j = 0; j < NP - 1; j++) begin : g_inner
        assign node[j] = node[2*j+1] + node[2*j+2];
    end

    assign sum = node[0];

endmodule

// File: rtl/gln_quantizer.sv
module gln_quantizer #(
    parameter int SUM_W = 5,
    parameter int OUT_W = 2
) (
    input  logic signed [SUM_W-1:0]                 sum,
    input  logic [((1<<OUT_W)-1)*SUM_W-1:0]         thr_flat,
    output logic [OUT_W-1:0]                        code
);
    localparam int N_TH = (1 << OUT_W) - 1;

    always_comb begin
        code = '0;
        for (int k = 0; k < N_TH; k++) begin
            if (sum >= $signed(thr_flat[k*SUM_W +: SUM_W]))
                code = code + OUT_W'(1);
        end
    end

endmodule

// File: rtl/grouped_lut_neuron.sv
module grouped_lut_neuron
    import gln_pkg::*;
#(
    parameter int A      = 2,
    parameter int F      = 6,
    parameter int BETA   = 2,
    parameter int P_W    = 4,
    parameter int OUT_W  = 2,
    parameter int STAGES = 2,
    localparam int ADDR_W = F * BETA,
    localparam int IN_W   = A * ADDR_W,
    localparam int SUM_W  = P_W + $clog2(A),
    localparam int TGT_W  = $clog2(A + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_vec,
    input  logic              cfg_we,
    input  logic [TGT_W-1:0]  cfg_tgt,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [SUM_W-1:0]  cfg_wdata,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_code
);
    localparam int N_TH = (1 << OUT_W) - 1;

    gln_tgt_e tgt_kind;
    logic [A*P_W-1:0]        parts_c;
    logic [A*P_W-1:0]        parts_s;
    logic                    v_s;
    logic signed [SUM_W-1:0] sum;
    logic [OUT_W-1:0]        code_c;
    logic signed [SUM_W-1:0] thr [N_TH];
    logic [N_TH*SUM_W-1:0]   thr_flat;
    logic [1:0]              since_rst;

    assign tgt_kind = gln_decode(32'(cfg_tgt), A);

    // Per-group sub-tables: group g reads its own slice of the input vector
    for (genvar g = 0; g < A; g++) begin : g_grp
        logic we_g;
        assign we_g = cfg_we && (tgt_kind == GLN_TGT_TABLE) && (cfg_tgt == TGT_W'(g));
        gln_subtable #(
            .ADDR_W (ADDR_W),
            .P_W    (P_W)
        ) u_tab (
            .clk   (clk),
            .we    (we_g),
            .waddr (cfg_addr),
            .wdata (cfg_wdata[P_W-1:0]),
            .raddr (in_vec[g*ADDR_W +: ADDR_W]),
            .rdata (parts_c[g*P_W +: P_W])
        );
    end

    // Threshold bank
    always_ff @(posedge clk) begin
        if (cfg_we && (tgt_kind == GLN_TGT_THRESH) && (cfg_addr < ADDR_W'(N_TH)))
            thr[cfg_addr[$clog2(N_TH+1)-1:0]] <= cfg_wdata;
    end

    for (genvar k = 0; k < N_TH; k++) begin : g_thr
        assign thr_flat[k*SUM_W +: SUM_W] = thr[k];
    end

    // Optional register after the lookup
    if (STAGES >= 2) begin : g_two
        logic             v1;
        logic [A*P_W-1:0] parts_q;
        always_ff @(posedge clk) begin
            if (rst)
                v1 <= 1'b0;
            else
                v1 <= in_valid;
            parts_q <= parts_c;
        end
        assign parts_s = parts_q;
        assign v_s     = v1;
    end else begin : g_one
        assign parts_s = parts_c;
        assign v_s     = in_valid;
    end

    gln_adder_tree #(
        .A     (A),
        .P_W   (P_W),
        .SUM_W (SUM_W)
    ) u_add (
        .parts (parts_s),
        .sum   (sum)
    );

    gln_quantizer #(
        .SUM_W (SUM_W),
        .OUT_W (OUT_W)
    ) u_q (
        .sum      (sum),
        .thr_flat (thr_flat),
        .code     (code_c)
    );

    // Output register: code only updates with a valid result
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= v_s;
            if (v_s)
                out_code <= code_c;
        end
    end

    // ---------------- assertions ----------------
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    logic all_nn, all_neg, th_asc;
    always_comb begin
        all_nn  = 1'b1;
        all_neg = 1'b1;
        for (int i = 0; i < A; i++) begin
            if (parts_s[i*P_W+P_W-1]) all_nn = 1'b0;
            else                      all_neg = 1'b0;
        end
        th_asc = 1'b1;
        for (int k = 1; k < N_TH; k++)
            if (thr[k] < thr[k-1]) th_asc = 1'b0;
    end

    if (STAGES >= 2) begin : g_lat2
        p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
    end else begin : g_lat1
        p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd1) |-> (out_valid == $past(in_valid)));
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (all_nn |-> (sum >= 0)) and (all_neg |-> (sum < 0)));

    p_code_low_r4: assert property (@(posedge clk) disable iff (rst)
        (th_asc && (sum < thr[0])) |-> (code_c == '0));

    p_code_high_r4: assert property (@(posedge clk) disable iff (rst)
        (th_asc && (sum >= thr[N_TH-1])) |-> (code_c == OUT_W'(N_TH)));

    p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !v_s |=> $stable(out_code));

    p_load_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !in_valid);

endmodule

// File: tb/grouped_lut_neuron_bench.sv
module grouped_lut_neuron_bench;

    localparam int A = 2, F = 6, BETA = 2, P_W = 4, OUT_W = 2;
    localparam int AW = F * BETA;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_vec = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_tgt = '0;
    logic [11:0] cfg_addr = '0;
    logic [4:0]  cfg_wdata = '0;
    logic        ov2, ov1;
    logic [1:0]  oc2, oc1;

    always #10 clk = ~clk;

    grouped_lut_neuron #(.A(A), .F(F), .BETA(BETA), .P_W(P_W), .OUT_W(OUT_W), .STAGES(2))
    u_grouped_lut_neuron (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(ov2), .out_code(oc2));

    grouped_lut_neuron #(.A(A), .F(F), .BETA(BETA), .P_W(P_W), .OUT_W(OUT_W), .STAGES(1))
    u_grouped_lut_neuron_s1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(ov1), .out_code(oc1));

    int n_chk = 0, n_bad = 0, cyc = 0;
    int tbl0 [DEPTH];
    int tbl1 [DEPTH];
    int mthr [3];
    int    q2_code[$], q2_due[$], q1_code[$], q1_due[$];
    string q2_tag[$], q1_tag[$];
    int last2 = 0, last1 = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int model(input int a0, input int a1);
        int s = tbl0[a0] + tbl1[a1];
        int c = 0;
        for (int k = 0; k < 3; k++) if (s >= mthr[k]) c++;
        return c;
    endfunction

    task automatic cfg_write(input int tgt, input int addr, input int val);
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_tgt   = 2'(tgt);
        cfg_addr  = 12'(addr);
        cfg_wdata = 5'(val);
        if (tgt == 0) tbl0[addr] = val;
        else if (tgt == 1) tbl1[addr] = val;
        else if (tgt == 2 && addr < 3) mthr[addr] = val;
    endtask

    // Driver: presents one vector and pushes the expected item for both instances
    task automatic send(input int a0, input int a1, input string tag);
        int e;
        @(negedge clk);
        cfg_we   = 1'b0;
        in_valid = 1'b1;
        in_vec   = {12'(a1), 12'(a0)};
        e = model(a0, a1);
        q2_code.push_back(e); q2_due.push_back(cyc + 2); q2_tag.push_back(tag);
        q1_code.push_back(e); q1_due.push_back(cyc + 1); q1_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cfg_we   = 1'b0;
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (ov2) begin
                if (q2_code.size() == 0) begin
                    check(1'b0, "R5 unexpected pulse S2", 1, 0);
                end else begin
                    int e, d; string t;
                    e = q2_code.pop_front(); d = q2_due.pop_front(); t = q2_tag.pop_front();
                    check(cyc == d, "R5 latency S2", cyc, d);
                    check(int'(oc2) == e, {t, " code S2"}, int'(oc2), e);
                    last2 = int'(oc2);
                end
            end else begin
                check(int'(oc2) == last2, "R8 hold S2", int'(oc2), last2);
            end
            if (ov1) begin
                if (q1_code.size() == 0) begin
                    check(1'b0, "R5 unexpected pulse S1", 1, 0);
                end else begin
                    int e, d; string t;
                    e = q1_code.pop_front(); d = q1_due.pop_front(); t = q1_tag.pop_front();
                    check(cyc == d, "R5 latency S1", cyc, d);
                    check(int'(oc1) == e, {t, " code S1"}, int'(oc1), e);
                    last1 = int'(oc1);
                end
            end else begin
                check(int'(oc1) == last1, "R8 hold S1", int'(oc1), last1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        check(ov2 == 1'b0 && oc2 == 2'd0, "R1 during reset S2", int'(oc2), 0);
        check(ov1 == 1'b0 && oc1 == 2'd0, "R1 during reset S1", int'(oc1), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(ov2 == 1'b0 && oc2 == 2'd0, "R1 after release S2", int'(ov2), 0);
        check(ov1 == 1'b0 && oc1 == 2'd0, "R1 after release S1", int'(ov1), 0);

        // R7: load both sub-tables and the thresholds
        for (int g = 0; g < 2; g++)
            for (int a = 0; a < DEPTH; a++)
                cfg_write(g, a, ((a * 37 + g * 11 + (a >> 5)) % 16) - 8);
        cfg_write(2, 0, -3);
        cfg_write(2, 1, 0);
        cfg_write(2, 2, 6);
        // Corner entries (overwrites also exercise R7)
        cfg_write(0, 5, 3);   cfg_write(1, 9, -3);
        cfg_write(0, 6, -1);  cfg_write(1, 10, -2);
        cfg_write(0, 7, -1);  cfg_write(1, 11, -3);
        cfg_write(0, 8, 3);   cfg_write(1, 12, 3);
        cfg_write(0, 4095, 7); cfg_write(1, 4095, 7);
        cfg_write(0, 0, -8);  cfg_write(1, 0, -8);
        idle(2);

        // R4: threshold equality and neighbours
        send(5, 9, "R4 sum=0 equals thr");
        send(6, 10, "R4 sum=-3 equals thr");
        send(7, 11, "R4 sum=-4 below all");
        send(8, 12, "R4 sum=6 meets top");
        // R3: extremes
        send(4095, 4095, "R3 max sum");
        send(0, 0, "R3 min sum");
        // R2: only one group changes
        send(5, 12, "R2 group1 slice");
        send(8, 9, "R2 group0 slice");
        idle(4);

        // R6: back-to-back stream
        for (int i = 0; i < 60; i++)
            send(int'($urandom % DEPTH), int'($urandom % DEPTH), "R6 stream");
        idle(4);

        // R7: ignored writes (target above A, threshold index beyond bank)
        cfg_write(3, 5, -8);
        cfg_write(3, 9, 7);
        cfg_write(2, 3, 15);
        idle(2);
        send(5, 9, "R7 ignored writes");
        idle(4);

        // New thresholds around the extremes
        cfg_write(2, 0, -16);
        cfg_write(2, 1, 13);
        cfg_write(2, 2, 14);
        idle(2);
        send(4095, 4095, "R3 max meets top thr");
        send(0, 0, "R3 min equals low thr");
        send(5, 9, "R4 new thresholds");
        for (int i = 0; i < 20; i++)
            send(int'($urandom % DEPTH), int'($urandom % DEPTH), "R6 stream 2");
        idle(6);

        check(q2_code.size() == 0, "R5 all delivered S2", q2_code.size(), 0);
        check(q1_code.size() == 0, "R5 all delivered S1", q1_code.size(), 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule